// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the two active-low DMA request pins of a 16550-style serial port: a receive-side request that tells a DMA engine characters are waiting, and a transmit-side request that tells it room is available. It watches the occupancy counts of the receive and transmit FIFOs, the FIFO enable, the DMA mode select and the 2-bit receive trigger selector from the FIFO control register, the receive and transmit FIFO clear pulses, and a character-timeout indication from the receive timer. It also reports whether the receive FIFO has reached its trigger level.

Two request modes exist. In single-transfer mode, selected when the FIFOs are disabled or the mode select is clear, each request simply reflects whether data is waiting or whether the transmit side is empty. In multi-transfer mode, selected when the FIFOs are enabled and the mode select is set, the receive request waits for the trigger level or a timeout and then holds until the receive FIFO drains, and the transmit request stays active from empty until the transmit FIFO is entirely full. All three outputs are registered, so each reflects the inputs of the previous clock. The interface carries only level-type control and status, so it has no valid/ready handshake and no back-pressure.

Top module: `uart_dma_ready`

## Requirements
- R1: During and straight after reset, both request outputs are high (inactive) and the trigger flag is low.
- R2: In single-transfer mode the receive request is low one clock after the receive count is non-zero and high one clock after it is zero.
- R3: In multi-transfer mode the receive request goes low one clock after the receive count reaches the selected level; the selector encodes 2'b00=1, 2'b01=DEPTH/4, 2'b10=DEPTH/2, 2'b11=DEPTH-2 characters (1, 4, 8, 14 at depth 16); below that level it stays high.
- R4: In multi-transfer mode a timeout indication with a non-zero receive count drives the receive request low one clock later, whatever the level.
- R5: In multi-transfer mode the receive request, once low, stays low while the receive count is non-zero and goes high one clock after the count is zero.
- R6: In single-transfer mode the transmit request is low one clock after the transmit count is zero and high one clock after it is non-zero.
- R7: In multi-transfer mode the transmit request goes low one clock after the transmit count is zero, stays low while partly filled, goes high one clock after the count equals DEPTH, and stays high until the count is zero again.
- R8: A receive clear pulse makes the receive count count as zero in that cycle (receive request high next clock, even with a timeout); a transmit clear pulse does the same for the transmit count (transmit request low next clock).
- R9: With the FIFOs disabled, the mode select is ignored and both requests follow single-transfer behaviour.
- R10: The trigger flag is high one clock after the FIFOs are enabled and the effective receive count is at or above the selected level, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable bit of the FIFO control register |
| dma_sel | input | 1 | DMA mode select (1 = multi-transfer when FIFOs are enabled) |
| trig_sel | input | 2 | Receive trigger level selector |
| rx_clr | input | 1 | Receive FIFO clear pulse |
| tx_clr | input | 1 | Transmit FIFO clear pulse |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_timeout | input | 1 | Receive character timeout indication |
| rx_ready_n | output | 1 | Receive DMA request, active low |
| tx_ready_n | output | 1 | Transmit DMA request, active low |
| rx_trig_hit | output | 1 | Receive trigger level reached |

## Verification
The receive clear pulse and the request-setting causes can land in the same cycle: a clear arriving together with a timeout and a count above the trigger level must win, leaving the receive request high. The bench provokes this by holding a non-zero count, raising the timeout and the clear in one cycle, and judging the request one clock later; the transmit side is driven the same way with a full count and a clear pulse, where the clear must turn the request on instead of leaving it off.

// File: rtl/uart_dma_ready_pkg.sv
package uart_dma_ready_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE     = 2'b00,
    TRIG_QUARTER = 2'b01,
    TRIG_HALF    = 2'b10,
    TRIG_NEAR    = 2'b11
  } trig_sel_e;

  // Number of characters needed to hit each trigger selection.
  function automatic int unsigned trig_chars(input logic [1:0] sel,
                                             input int unsigned depth);
    case (sel)
      TRIG_ONE:     trig_chars = 1;
      TRIG_QUARTER: trig_chars = depth / 4;
      TRIG_HALF:    trig_chars = depth / 2;
      default:      trig_chars = depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
  import uart_dma_ready_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             burst_mode,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] level_eff,
  input  logic             timeout,
  output logic             req,
  output logic             trig_hit
);

  localparam int unsigned NLVL = 4;

  logic [CNT_W-1:0] lvl_tab [NLVL];
  logic [CNT_W-1:0] lvl_now;
  logic             at_lvl;
  logic             empty;
  logic             req_d;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_tab[g] = CNT_W'(trig_chars(2'(g), DEPTH));
  end

  assign lvl_now = lvl_tab[trig_sel];
  assign at_lvl  = (level_eff >= lvl_now);
  assign empty   = (level_eff == '0);

  always_comb begin
    if (empty) begin
      req_d = 1'b0;
    end else if (!burst_mode) begin
      req_d = 1'b1;
    end else begin
      req_d = req | at_lvl | timeout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req      <= 1'b0;
      trig_hit <= 1'b0;
    end else begin
      req      <= req_d;
      trig_hit <= fifo_en & at_lvl;
    end
  end

  AST_RX_SINGLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_mode && !empty) |=> req) else $error("rx single set"); // R2
  AST_RX_TIMEOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && timeout && !empty) |=> req) else $error("rx timeout"); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && req && !empty) |=> req) else $error("rx hold"); // R5
  AST_RX_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !req) else $error("rx release"); // R5
  AST_RX_BURST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && !req && !at_lvl && !timeout) |=> !req) else $error("rx early"); // R3

endmodule

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_mode,
  input  logic [CNT_W-1:0] level_eff,
  output logic             req
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic empty;
  logic full;
  logic req_d;

  assign empty = (level_eff == '0);
  assign full  = (level_eff >= FULL_CNT);

  always_comb begin
    if (empty) begin
      req_d = 1'b1;
    end else if (!burst_mode || full) begin
      req_d = 1'b0;
    end else begin
      req_d = req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else begin
      req <= req_d;
    end
  end

  AST_TX_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> req) else $error("tx empty"); // R6
  AST_TX_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_mode && !empty) |=> !req) else $error("tx single"); // R6
  AST_TX_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && full) |=> !req) else $error("tx full"); // R7
  AST_TX_PARTIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && !empty && !full) |=> (req == $past(req))) else $error("tx hold"); // R7

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             dma_sel,
  input  logic [1:0]       trig_sel,
  input  logic             rx_clr,
  input  logic             tx_clr,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_timeout,
  output logic             rx_ready_n,
  output logic             tx_ready_n,
  output logic             rx_trig_hit
);

  logic             burst_mode;
  logic [CNT_W-1:0] rx_eff;
  logic [CNT_W-1:0] tx_eff;
  logic             rx_req;
  logic             tx_req;

  // Multi-transfer behaviour only exists with the FIFOs switched on.
  assign burst_mode = fifo_en & dma_sel;
  // A clear pulse empties the FIFO in the same cycle it is seen.
  assign rx_eff = rx_clr ? '0 : rx_count;
  assign tx_eff = tx_clr ? '0 : tx_count;

  uart_dma_rx_req #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .burst_mode (burst_mode),
    .trig_sel   (trig_sel),
    .level_eff  (rx_eff),
    .timeout    (rx_timeout),
    .req        (rx_req),
    .trig_hit   (rx_trig_hit)
  );

  uart_dma_tx_req #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_mode (burst_mode),
    .level_eff  (tx_eff),
    .req        (tx_req)
  );

  assign rx_ready_n = ~rx_req;
  assign tx_ready_n = ~tx_req;

  AST_RX_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> rx_ready_n) else $error("rx clear"); // R8
  AST_TX_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> !tx_ready_n) else $error("tx clear"); // R8
  AST_DISABLED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_count != '0 && !rx_clr) |=> !rx_ready_n) else $error("disabled"); // R9
  AST_TRIG_NEEDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !rx_trig_hit) else $error("trig flag"); // R10

endmodule

// File: tb/uart_dma_ready_test.sv
`timescale 1ns/100ps
module uart_dma_ready_test;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fifo_en = 1'b0;
  logic             dma_sel = 1'b0;
  logic [1:0]       trig_sel = 2'b00;
  logic             rx_clr = 1'b0;
  logic             tx_clr = 1'b0;
  logic [CNT_W-1:0] rx_count = '0;
  logic [CNT_W-1:0] tx_count = '0;
  logic             rx_timeout = 1'b0;
  logic             rx_ready_n;
  logic             tx_ready_n;
  logic             rx_trig_hit;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  uart_dma_ready #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_sel(dma_sel),
    .trig_sel(trig_sel), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .rx_count(rx_count), .tx_count(tx_count), .rx_timeout(rx_timeout),
    .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n), .rx_trig_hit(rx_trig_hit)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check(rx_ready_n, 1'b1, "R1 rx idle");
    check(tx_ready_n, 1'b1, "R1 tx idle");
    check(rx_trig_hit, 1'b0, "R1 trig idle");
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_single_rx();
    fifo_en = 1'b1; dma_sel = 1'b0; rx_count = 0; tick();
    check(rx_ready_n, 1'b1, "R2 empty");
    rx_count = 3; tick();
    check(rx_ready_n, 1'b0, "R2 data");
    rx_count = 0; tick();
    check(rx_ready_n, 1'b1, "R2 drained");
  endtask

  task automatic t_burst_level(input logic [1:0] sel, input int lvl);
    fifo_en = 1'b1; dma_sel = 1'b1; trig_sel = sel; rx_count = 0; tick();
    rx_count = CNT_W'(lvl - 1); tick();
    check(rx_ready_n, (lvl - 1) == 0 ? 1'b1 : 1'b1, "R3 below level");
    check(rx_trig_hit, 1'b0, "R10 below level");
    rx_count = CNT_W'(lvl); tick();
    check(rx_ready_n, 1'b0, "R3 at level");
    check(rx_trig_hit, 1'b1, "R10 at level");
    rx_count = 0; tick();
    check(rx_ready_n, 1'b1, "R5 empty release");
  endtask

  task automatic t_burst_hold();
    fifo_en = 1'b1; dma_sel = 1'b1; trig_sel = 2'b01; rx_count = 4; tick();
    rx_count = 2; tick();
    check(rx_ready_n, 1'b0, "R5 hold below level");
    check(rx_trig_hit, 1'b0, "R10 dropped");
    rx_count = 1; tick();
    check(rx_ready_n, 1'b0, "R5 hold one left");
    rx_count = 0; tick();
    check(rx_ready_n, 1'b1, "R5 release");
  endtask

  task automatic t_timeout();
    fifo_en = 1'b1; dma_sel = 1'b1; trig_sel = 2'b10; rx_count = 0;
    rx_timeout = 1'b1; tick();
    check(rx_ready_n, 1'b1, "R4 timeout empty");
    rx_count = 2; tick();
    check(rx_ready_n, 1'b0, "R4 timeout data");
    rx_timeout = 1'b0; tick();
    check(rx_ready_n, 1'b0, "R5 hold after timeout");
    rx_count = 0; tick();
    check(rx_ready_n, 1'b1, "R5 release after timeout");
  endtask

  task automatic t_single_tx();
    fifo_en = 1'b1; dma_sel = 1'b0; tx_count = 0; tick();
    check(tx_ready_n, 1'b0, "R6 empty");
    tx_count = 1; tick();
    check(tx_ready_n, 1'b1, "R6 loaded");
    tx_count = 0; tick();
    check(tx_ready_n, 1'b0, "R6 empty again");
  endtask

  task automatic t_burst_tx();
    fifo_en = 1'b1; dma_sel = 1'b1; tx_count = 0; tick();
    check(tx_ready_n, 1'b0, "R7 empty");
    tx_count = 5; tick();
    check(tx_ready_n, 1'b0, "R7 partial stays");
    tx_count = CNT_W'(DEPTH - 1); tick();
    check(tx_ready_n, 1'b0, "R7 one short");
    tx_count = CNT_W'(DEPTH); tick();
    check(tx_ready_n, 1'b1, "R7 full");
    tx_count = 5; tick();
    check(tx_ready_n, 1'b1, "R7 partial stays off");
    tx_count = 0; tick();
    check(tx_ready_n, 1'b0, "R7 empty again");
  endtask

  task automatic t_clear();
    fifo_en = 1'b1; dma_sel = 1'b1; trig_sel = 2'b00; rx_count = 5; tick();
    check(rx_ready_n, 1'b0, "R8 rx armed");
    rx_clr = 1'b1; rx_timeout = 1'b1; tick();
    check(rx_ready_n, 1'b1, "R8 rx clear wins");
    check(rx_trig_hit, 1'b0, "R10 cleared");
    rx_clr = 1'b0; rx_timeout = 1'b0; rx_count = 0;
    tx_count = CNT_W'(DEPTH); tick();
    check(tx_ready_n, 1'b1, "R8 tx full");
    tx_clr = 1'b1; tick();
    check(tx_ready_n, 1'b0, "R8 tx clear");
    tx_clr = 1'b0; tx_count = 0; tick();
  endtask

  task automatic t_disabled();
    fifo_en = 1'b0; dma_sel = 1'b1; trig_sel = 2'b11; rx_count = 1; tx_count = 0; tick();
    check(rx_ready_n, 1'b0, "R9 rx single");
    check(rx_trig_hit, 1'b0, "R10 disabled");
    tx_count = 1; tick();
    check(tx_ready_n, 1'b1, "R9 tx single");
    rx_count = 0; tx_count = 0; tick();
    check(rx_ready_n, 1'b1, "R9 rx empty");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_single_rx();
    t_burst_level(2'b00, 1);
    t_burst_level(2'b01, 4);
    t_burst_level(2'b10, 8);
    t_burst_level(2'b11, 14);
    t_burst_hold();
    t_timeout();
    t_single_tx();
    t_burst_tx();
    t_clear();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule